// File: doc/BRIEF.md
# Data-Processing Execute Stage with Rotated Immediate

This block is the execute stage for the data-processing class of a 32-bit RISC instruction set that has 5-bit register specifiers. An issue stage hands it a 32-bit instruction word together with the values already read for the first source register (Rn), the shifted register (Rm) and the shift-amount register (Rs), plus the current NZCV flags. The block builds the second operand from one of three sources, performs one of sixteen ALU operations, and one clock later presents the destination specifier, the result, a write enable and the updated flags.

The second operand comes from one of three sources. It can be Rm shifted by a 5-bit constant, Rm shifted by the low byte of Rs, or a 9-bit constant rotated left by a 5-bit amount. The instruction set has no general predication. MOV and MVN instead reuse their unused Rn field as a condition code, so a conditional move needs no branch. Compare and test operations change only the flags.

Top module: `exec_unit`

## Requirements
- R1: Instruction fields are class [31:29], opcode [28:25], S [24], Rn [23:19], Rd [18:14], amount/Rs [13:9], shift type [7:6], shift source [5] and Rm [4:0]. Class 000 is the register form. With [5]=0, Rm is shifted by the constant in [13:9], and the shift type codes are 00 LSL, 01 LSR, 10 ASR and 11 ROR. An amount of 0 passes Rm unchanged and keeps the incoming C.
- R2: With class 000 and [5]=1, the shift amount is Rs[7:0]. An amount of 0 passes Rm and keeps C. LSL by 32 gives 0 with C=Rm[0], and LSL by more than 32 gives 0 with C=0. LSR by 32 gives 0 with C=Rm[31], and LSR by more than 32 gives 0 with C=0. ASR by 32 or more fills every bit with Rm[31] and sets C=Rm[31]. ROR by a nonzero multiple of 32 gives Rm with C=Rm[31]. Any other ROR rotates by amount mod 32, and C is result bit 31.
- R3: Class 001 is the immediate form. Operand 2 is [8:0], zero-extended and rotated left by [13:9]. The shifter carry is result bit 0 when the rotation is nonzero, and the incoming C when the rotation is 0.
- R4: The opcodes are 0 AND, 1 EOR, 2 SUB, 3 RSB, 4 ADD, 5 ADC, 6 SBC, 7 RSC, 8 TST, 9 TEQ, 10 CMP, 11 CMN, 12 ORR, 13 MOV, 14 BIC and 15 MVN. Arithmetic operations set C from the adder carry-out, where for subtraction C=1 means no borrow. They set V from signed overflow. ADC, SBC and RSC add the incoming C.
- R5: Logical operations set N and Z from the result, take C from the shifter carry and keep V.
- R6: TST, TEQ, CMP and CMN never assert the write enable and always update the flags, whatever the value of S.
- R7: For MOV and MVN, Rn[3:0] is a condition code. The codes are EQ, NE, CS, CC, MI, PL, VS, VC, HI, LS, GE, LT, GT and LE as 0 to 13, and 14 and 15 mean always. When the condition fails on the incoming flags, there is neither a register write nor a flag update.
- R8: A non-compare operation with S=0 does not update the flags, and flags_o equals flags_in.
- R9: Any class other than 000 or 001 gives result 0, no write, no flag update, and flags_o equal to flags_in.
- R10: The outputs are registered and describe the instruction issued one cycle earlier. A cycle with in_vld=0 gives out_vld=0 and all other outputs 0 in the next cycle.
- R11: While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_vld | input | 1 | Instruction issued this cycle |
| instr | input | 32 | Instruction word |
| rn_val | input | 32 | Value of Rn |
| rm_val | input | 32 | Value of Rm |
| rs_val | input | 32 | Value of Rs |
| flags_in | input | 4 | Current NZCV flags, N in bit 3 |
| out_vld | output | 1 | Result stage holds an instruction |
| rd_o | output | 5 | Destination specifier |
| wr_en_o | output | 1 | Write result to Rd |
| result_o | output | 32 | ALU result |
| flags_we_o | output | 1 | Flags updated |
| flags_o | output | 4 | NZCV after the instruction |

## Verification
The only state in the block is the one-stage result register. A wrong capture therefore appears at the ports in the cycle right after the issue, as a result, flag or enable value that differs from the instruction just sent. The shifter's saturation and carry corner cases are reached only through particular amounts. For that reason the stimulus biases Rs toward amounts near 0, 32 and above, and it drives every rotation edge directly. A condition evaluated on the wrong flag shows up as a spurious or missing write, and it shows up only when the chosen flag pattern makes the correct and the wrong code disagree. The flags are therefore randomised for every instruction.

// File: rtl/exec_pkg.sv
package exec_pkg;
    localparam int DW = 32;
    localparam int RW = 5;
    localparam int FW = 4;

    typedef enum logic [3:0] {
        OP_AND, OP_EOR, OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC,
        OP_TST, OP_TEQ, OP_CMP, OP_CMN, OP_ORR, OP_MOV, OP_BIC, OP_MVN
    } alu_op_e;

    typedef enum logic [1:0] {SH_LSL, SH_LSR, SH_ASR, SH_ROR} shift_e;

    typedef struct packed {
        logic          vld;
        logic          wr_en;
        logic [RW-1:0] rd;
        logic [DW-1:0] data;
        logic          flags_we;
        logic [FW-1:0] flags;
    } stage_t;
endpackage

// File: rtl/operand2_gen.sv
module operand2_gen
    import exec_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         imm_form,
    input  logic [13:0]  fld,
    input  logic [W-1:0] rm_val,
    input  logic [7:0]   rs_amt,
    input  logic         c_in,
    output logic [W-1:0] op2,
    output logic         c_out
);
    localparam int AW = $clog2(W);

    logic [W-1:0]          imm_ext;
    logic [AW-1:0]         rot;
    logic [7:0]            amt;
    logic [7:0]            asr_amt;
    logic [2*W-1:0]        wide;
    logic signed [2*W-1:0] swide;
    shift_e                sh;

    always_comb begin
        imm_ext = {{(W-9){1'b0}}, fld[8:0]};
        rot     = fld[9+AW-1:9];
        sh      = shift_e'(fld[7:6]);
        amt     = fld[5] ? rs_amt : {{(8-AW){1'b0}}, fld[9+AW-1:9]};
        asr_amt = (amt > 8'(W)) ? 8'(W) : amt;
        wide    = '0;
        swide   = '0;
        op2     = rm_val;
        c_out   = c_in;
        if (imm_form) begin
            op2   = (imm_ext << rot) | (imm_ext >> (W - int'(rot)));
            c_out = (rot == '0) ? c_in : op2[0];
        end else if (amt != 8'd0) begin
            unique case (sh)
                SH_LSL: begin
                    wide  = {{W{1'b0}}, rm_val} << amt;
                    op2   = (amt > 8'(W)) ? '0 : wide[W-1:0];
                    c_out = (amt > 8'(W)) ? 1'b0 : wide[W];
                end
                SH_LSR: begin
                    wide  = {rm_val, {W{1'b0}}} >> amt;
                    op2   = (amt > 8'(W)) ? '0 : wide[2*W-1:W];
                    c_out = (amt > 8'(W)) ? 1'b0 : wide[W-1];
                end
                SH_ASR: begin
                    swide = $signed({rm_val, {W{1'b0}}}) >>> asr_amt;
                    op2   = swide[2*W-1:W];
                    c_out = swide[W-1];
                end
                SH_ROR: begin
                    if (amt[AW-1:0] == '0) begin
                        op2   = rm_val;
                        c_out = rm_val[W-1];
                    end else begin
                        op2   = (rm_val >> amt[AW-1:0]) | (rm_val << (W - int'(amt[AW-1:0])));
                        c_out = op2[W-1];
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import exec_pkg::*;
#(
    parameter int W = DW
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         c_in,
    input  logic         v_in,
    input  logic         sh_c,
    output logic [W-1:0] res,
    output logic [3:0]   nzcv
);
    logic [W-1:0] x, y;
    logic         ci;
    logic         arith;
    logic [W:0]   sum;
    logic         c_new, v_new;

    always_comb begin
        x     = a;
        y     = b;
        ci    = 1'b0;
        arith = 1'b1;
        unique case (op)
            OP_SUB, OP_CMP: begin y = ~b; ci = 1'b1; end
            OP_RSB:         begin x = b; y = ~a; ci = 1'b1; end
            OP_ADD, OP_CMN: ci = 1'b0;
            OP_ADC:         ci = c_in;
            OP_SBC:         begin y = ~b; ci = c_in; end
            OP_RSC:         begin x = b; y = ~a; ci = c_in; end
            default:        arith = 1'b0;
        endcase
        sum   = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
        c_new = arith ? sum[W] : sh_c;
        v_new = arith ? ((x[W-1] == y[W-1]) && (sum[W-1] != x[W-1])) : v_in;
        unique case (op)
            OP_AND, OP_TST: res = a & b;
            OP_EOR, OP_TEQ: res = a ^ b;
            OP_ORR:         res = a | b;
            OP_MOV:         res = b;
            OP_BIC:         res = a & ~b;
            OP_MVN:         res = ~b;
            default:        res = sum[W-1:0];
        endcase
        nzcv = {res[W-1], (res == '0), c_new, v_new};
    end
endmodule

// File: rtl/cond_eval.sv
module cond_eval (
    input  logic [3:0] cond,
    input  logic [3:0] nzcv,
    output logic       pass
);
    logic n, z, c, v;

    always_comb begin
        {n, z, c, v} = nzcv;
        unique case (cond)
            4'd0:    pass = z;
            4'd1:    pass = !z;
            4'd2:    pass = c;
            4'd3:    pass = !c;
            4'd4:    pass = n;
            4'd5:    pass = !n;
            4'd6:    pass = v;
            4'd7:    pass = !v;
            4'd8:    pass = c && !z;
            4'd9:    pass = !c || z;
            4'd10:   pass = (n == v);
            4'd11:   pass = (n != v);
            4'd12:   pass = !z && (n == v);
            4'd13:   pass = z || (n != v);
            default: pass = 1'b1;
        endcase
    end
endmodule

// File: rtl/exec_unit.sv
module exec_unit
    import exec_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [31:0]   instr,
    input  logic [DW-1:0] rn_val,
    input  logic [DW-1:0] rm_val,
    input  logic [DW-1:0] rs_val,
    input  logic [FW-1:0] flags_in,
    output logic          out_vld,
    output logic [RW-1:0] rd_o,
    output logic          wr_en_o,
    output logic [DW-1:0] result_o,
    output logic          flags_we_o,
    output logic [FW-1:0] flags_o
);
    stage_t        stage_d, stage_q;
    logic [DW-1:0] op2, alu_res;
    logic          sh_c, cond_ok;
    logic [3:0]    alu_flags;
    alu_op_e       op;
    logic          is_alu, is_cmp, is_mov;
    logic          unused_bits;

    assign unused_bits = ^{rs_val[DW-1:8], instr[23]};
    assign op          = alu_op_e'(instr[28:25]);

    operand2_gen #(.W(DW)) u_op2 (
        .imm_form (instr[29]),
        .fld      (instr[13:0]),
        .rm_val   (rm_val),
        .rs_amt   (rs_val[7:0]),
        .c_in     (flags_in[1]),
        .op2      (op2),
        .c_out    (sh_c)
    );

    alu_core #(.W(DW)) u_alu (
        .op   (op),
        .a    (rn_val),
        .b    (op2),
        .c_in (flags_in[1]),
        .v_in (flags_in[0]),
        .sh_c (sh_c),
        .res  (alu_res),
        .nzcv (alu_flags)
    );

    cond_eval u_cond (
        .cond (instr[22:19]),
        .nzcv (flags_in),
        .pass (cond_ok)
    );

    always_comb begin
        is_alu  = (instr[31:30] == 2'b00);
        is_cmp  = (instr[28:27] == 2'b10);
        is_mov  = (op == OP_MOV) || (op == OP_MVN);
        stage_d = '0;
        if (in_vld) begin
            stage_d.vld   = 1'b1;
            stage_d.rd    = instr[18:14];
            stage_d.flags = flags_in;
            if (is_alu) begin
                stage_d.data = alu_res;
                if (!is_mov || cond_ok) begin
                    stage_d.wr_en = !is_cmp;
                    if (is_cmp || instr[24]) begin
                        stage_d.flags_we = 1'b1;
                        stage_d.flags    = alu_flags;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign out_vld    = stage_q.vld;
    assign rd_o       = stage_q.rd;
    assign wr_en_o    = stage_q.wr_en;
    assign result_o   = stage_q.data;
    assign flags_we_o = stage_q.flags_we;
    assign flags_o    = stage_q.flags;
endmodule

// File: rtl/exec_unit_chk.sv
module exec_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_vld,
    input logic [31:0] instr,
    input logic [31:0] rm_val,
    input logic [3:0]  flags_in,
    input logic        out_vld,
    input logic        wr_en_o,
    input logic        flags_we_o,
    input logic [3:0]  flags_o,
    input logic [31:0] result_o
);
    AST_WR_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> out_vld); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld && !wr_en_o && !flags_we_o); // R10
    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld && instr[31:30] == 2'b00 && instr[28:27] == 2'b10 |=> !wr_en_o && flags_we_o); // R6
    AST_S_CLEAR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld && instr[31:30] == 2'b00 && !instr[24] && instr[28:27] != 2'b10
        |=> !flags_we_o && flags_o == $past(flags_in)); // R8
    AST_OTHER_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld && instr[31:30] != 2'b00
        |=> !wr_en_o && !flags_we_o && result_o == 32'd0 && flags_o == $past(flags_in)); // R9
    AST_PLAIN_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld && instr[31:25] == 7'b0001101 && instr[22:19] == 4'd14 &&
        instr[13:9] == 5'd0 && !instr[5]
        |=> wr_en_o && result_o == $past(rm_val)); // R1
endmodule

bind exec_unit exec_unit_chk u_exec_unit_chk (.*);

// File: tb/test_exec_unit.sv
module test_exec_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [31:0] instr = '0, rn_val = '0, rm_val = '0, rs_val = '0;
    logic [3:0]  flags_in = '0;
    logic        out_vld, wr_en_o, flags_we_o;
    logic [4:0]  rd_o;
    logic [31:0] result_o;
    logic [3:0]  flags_o;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    bit          pend = 0;
    bit          e_vld, e_wr, e_fwe;
    bit [4:0]    e_rd;
    bit [31:0]   e_data;
    bit [3:0]    e_fl;
    string       tag_d, tag_f;

    always #2 clk = ~clk;

    exec_unit i_exec_unit (.*);

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit cond_ref(input int cc, input bit [3:0] f);
        bit n = f[3], z = f[2], c = f[1], v = f[0];
        case (cc)
            0: return z;            1: return !z;
            2: return c;            3: return !c;
            4: return n;            5: return !n;
            6: return v;            7: return !v;
            8: return c & !z;       9: return !c | z;
            10: return n == v;      11: return n != v;
            12: return !z & (n == v);
            13: return z | (n != v);
            default: return 1;
        endcase
    endfunction

    task automatic ref_model(input bit [31:0] ins, input bit [31:0] rn, input bit [31:0] rm,
                             input bit [31:0] rs, input bit [3:0] fl);
        int opc = ins[28:25];
        bit [31:0] b = rm;
        bit c = fl[1];
        bit v = fl[0];
        bit [31:0] x, y;
        bit ci;
        longint s;
        longint ss;
        bit arith = 1;
        bit is_cmp = (opc >= 8 && opc <= 11);
        bit is_mov = (opc == 13 || opc == 15);
        e_vld = 1; e_rd = ins[18:14]; e_wr = 0; e_fwe = 0; e_fl = fl; e_data = 0;
        tag_d = "R1"; tag_f = "R8";
        if (ins[31:30] != 2'b00) begin
            tag_d = "R9"; tag_f = "R9";
            return;
        end
        if (ins[29]) begin
            tag_d = "R3";
            b = {23'd0, ins[8:0]};
            for (int i = 0; i < int'(ins[13:9]); i++) begin
                b = {b[30:0], b[31]};
                c = b[0];
            end
        end else begin
            int amt = ins[5] ? int'(rs[7:0]) : int'(ins[13:9]);
            if (ins[5]) tag_d = "R2";
            for (int i = 0; i < amt; i++) begin
                case (ins[7:6])
                    2'd0: begin c = b[31]; b = b << 1; end
                    2'd1: begin c = b[0];  b = b >> 1; end
                    2'd2: begin c = b[0];  b = {b[31], b[31:1]}; end
                    default: begin c = b[0]; b = {b[0], b[31:1]}; end
                endcase
            end
        end
        x = rn; y = b; ci = 0;
        case (opc)
            2, 10: begin y = ~b; ci = 1; end
            3: begin x = b; y = ~rn; ci = 1; end
            4, 11: ci = 0;
            5: ci = fl[1];
            6: begin y = ~b; ci = fl[1]; end
            7: begin x = b; y = ~rn; ci = fl[1]; end
            default: arith = 0;
        endcase
        case (opc)
            0, 8: e_data = rn & b;
            1, 9: e_data = rn ^ b;
            12: e_data = rn | b;
            13: e_data = b;
            14: e_data = rn & ~b;
            15: e_data = ~b;
            default: begin
                s  = longint'(x) + longint'(y) + longint'(ci);
                ss = longint'($signed(x)) + longint'($signed(y)) + longint'(ci);
                e_data = s[31:0];
                c = s[32];
                v = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
            end
        endcase
        if (is_mov) tag_d = "R7";
        if (is_cmp) tag_d = "R6";
        if (is_mov && !cond_ref(int'(ins[22:19]), fl)) begin
            tag_f = "R7";
            return;
        end
        e_wr = !is_cmp;
        if (is_cmp || ins[24]) begin
            e_fwe = 1;
            tag_f = is_cmp ? "R6" : (arith ? "R4" : "R5");
            e_fl  = {e_data[31], e_data == 0, c, v};
        end
    endtask

    task automatic compare_out();
        if (!pend) return;
        chk("R10", "out_vld", out_vld, e_vld);
        chk(tag_d, "wr_en", wr_en_o, e_wr);
        chk(tag_d, "rd", rd_o, e_rd);
        chk(tag_d, "result", result_o, e_data);
        chk(tag_f, "flags_we", flags_we_o, e_fwe);
        chk(tag_f, "flags", flags_o, e_fl);
    endtask

    task automatic step(input bit v, input bit [31:0] ins, input bit [31:0] rn,
                        input bit [31:0] rm, input bit [31:0] rs, input bit [3:0] fl);
        @(negedge clk);
        compare_out();
        in_vld = v; instr = ins; rn_val = rn; rm_val = rm; rs_val = rs; flags_in = fl;
        if (v) ref_model(ins, rn, rm, rs, fl);
        else begin
            e_vld = 0; e_wr = 0; e_rd = 0; e_data = 0; e_fwe = 0; e_fl = 0;
            tag_d = "R10"; tag_f = "R10";
        end
        pend = 1;
    endtask

    function automatic bit [31:0] reg_ins(int op, bit s, int rn, int rd, int amt, bit src, int sh, int rm);
        return {3'b000, 4'(op), s, 5'(rn), 5'(rd), 5'(amt), 1'b0, 2'(sh), src, 5'(rm)};
    endfunction

    function automatic bit [31:0] imm_ins(int op, bit s, int rn, int rd, int rot, int imm);
        return {3'b001, 4'(op), s, 5'(rn), 5'(rd), 5'(rot), 9'(imm)};
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11", "reset out_vld", out_vld, 0);
        chk("R11", "reset wr_en", wr_en_o, 0);
        chk("R11", "reset result", result_o, 0);
        chk("R11", "reset flags", flags_o, 0);
        rst_n = 1'b1;
        // R1: plain move, LSL #4, ROR #8
        step(1, reg_ins(13, 1, 14, 3, 0, 0, 0, 1), 0, 32'h8000_0001, 0, 4'b0010);
        step(1, reg_ins(4, 0, 14, 3, 4, 0, 0, 1), 32'h10, 32'h0F00_000F, 0, 4'b0000);
        step(1, reg_ins(0, 1, 2, 3, 8, 0, 3, 1), 32'hFFFF_FFFF, 32'h1234_5681, 0, 4'b0001);
        // R2: register amounts 32, 33, 40, 64, 0
        step(1, reg_ins(13, 1, 14, 5, 0, 1, 0, 1), 0, 32'h0000_0001, 32'h20, 4'b0000);
        step(1, reg_ins(13, 1, 14, 5, 0, 1, 1, 1), 0, 32'h8000_0000, 32'h21, 4'b0010);
        step(1, reg_ins(13, 1, 14, 5, 0, 1, 1, 1), 0, 32'h8000_0000, 32'h20, 4'b0000);
        step(1, reg_ins(13, 1, 14, 5, 0, 1, 2, 1), 0, 32'h8000_0010, 32'h28, 4'b0000);
        step(1, reg_ins(13, 1, 14, 5, 0, 1, 3, 1), 0, 32'h8000_0010, 32'h40, 4'b0000);
        step(1, reg_ins(13, 1, 14, 5, 0, 1, 2, 1), 0, 32'h8000_0010, 32'h100, 4'b0010);
        // R3: rotation 0, 31, 28
        step(1, imm_ins(13, 1, 14, 6, 0, 9'h1FF), 0, 0, 0, 4'b0010);
        step(1, imm_ins(13, 1, 14, 6, 31, 9'h003), 0, 0, 0, 4'b0000);
        step(1, imm_ins(12, 1, 0, 6, 28, 9'h1F0), 32'h1, 0, 0, 4'b0000);
        // R4: overflow, equal subtract, carry chain, reverse subtract
        step(1, reg_ins(4, 1, 1, 7, 0, 0, 0, 2), 32'h7FFF_FFFF, 32'h1, 0, 4'b0000);
        step(1, reg_ins(2, 1, 1, 7, 0, 0, 0, 2), 32'h55, 32'h55, 0, 4'b0000);
        step(1, reg_ins(5, 1, 1, 7, 0, 0, 0, 2), 32'hFFFF_FFFF, 32'h0, 0, 4'b0010);
        step(1, reg_ins(7, 1, 1, 7, 0, 0, 0, 2), 32'h5, 32'h3, 0, 4'b0000);
        // R5: logical op keeps V, takes shifter carry
        step(1, reg_ins(14, 1, 1, 7, 1, 0, 1, 2), 32'hFFFF_FFFF, 32'h3, 0, 4'b0001);
        // R6: compare with S=0 still sets flags
        step(1, reg_ins(10, 0, 1, 7, 0, 0, 0, 2), 32'h3, 32'h5, 0, 4'b0000);
        // R7: MOVEQ with Z clear is dropped; MVNNE with Z clear writes
        step(1, reg_ins(13, 1, 0, 8, 0, 0, 0, 2), 0, 32'hAB, 0, 4'b0000);
        step(1, reg_ins(15, 1, 1, 8, 0, 0, 0, 2), 0, 32'hAB, 0, 4'b0000);
        // R8: ADD with S=0 keeps flags
        step(1, reg_ins(4, 0, 1, 9, 0, 0, 0, 2), 32'hFFFF_FFFF, 32'h1, 0, 4'b1001);
        // R9: other class
        step(1, 32'hA000_1234, 1, 2, 3, 4'b0110);
        // R10: idle cycle
        step(0, 32'h0000_0000, 0, 0, 0, 4'b1111);
        for (int k = 0; k < 4000; k++) begin
            bit [31:0] ins = $urandom;
            bit [31:0] rs  = $urandom;
            int sel = $urandom_range(0, 9);
            if (sel < 8) ins[31:30] = 2'b00;
            if ($urandom_range(0, 3) != 0) rs[7:0] = 8'($urandom_range(0, 40));
            step(sel != 9, ins, $urandom, $urandom, rs, 4'($urandom));
        end
        step(0, 0, 0, 0, 0, 0);
        @(negedge clk);
        compare_out();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule